// File: doc/BRIEF.md
# Two-Road Traffic Light Controller

This block sequences the signal lamps at a crossing of two roads, A and B. It is a Moore state machine with four phases. Road A keeps its green as long as its car sensor reports traffic. When that sensor goes quiet, road A gets one cycle of yellow and then road B gets green. Road B keeps its green while its own sensor is high, then gets one yellow cycle, and control returns to road A.

The light codes come only from the registered phase, so a sensor can change a light only through a clock edge. A compile-time parameter chooses how the phase is stored: a dense two-bit binary register or a four-bit one-hot register. Both choices drive the same codes on the light ports on every cycle. Reset is synchronous and active high. It puts road A on green and road B on red, and it overrides the sensors on the same edge.

Top module: `tlc_ctrl`

## Requirements
- R1: A clock edge with `rst` high puts the machine in the A-green phase, showing `light_a`=00 and `light_b`=10 after that edge, whatever the sensors show.
- R2: In the A-green phase, an edge with `sense_a` high keeps the machine in A-green. `sense_b` has no effect in this phase.
- R3: In the A-green phase, an edge with `sense_a` low moves the machine to the A-yellow phase.
- R4: The A-yellow phase always moves to the B-green phase on the next edge, whatever the sensors show.
- R5: In the B-green phase, an edge with `sense_b` high keeps the machine in B-green. `sense_a` has no effect in this phase.
- R6: In the B-green phase, an edge with `sense_b` low moves the machine to the B-yellow phase.
- R7: The B-yellow phase always returns to A-green on the next edge.
- R8: The light codes are green=00, yellow=01 and red=10, and 11 is never driven. The phases show the following codes as (A, B): A-green (00,10), A-yellow (01,10), B-green (10,00), B-yellow (10,01). At least one road is always red.
- R9: The light outputs depend only on the stored phase. A sensor change between clock edges leaves both outputs unchanged until the next edge.
- R10: Parameter `ONE_HOT`=0 stores the phases in binary as 00, 01, 10, 11. `ONE_HOT`=1 stores them as 0001, 0010, 0100, 1000. An illegal one-hot vector returns to A-green on the next edge. Both settings give identical light outputs for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_a | input | 1 | High while cars wait on road A |
| sense_b | input | 1 | High while cars wait on road B |
| light_a | output | 2 | Light code for road A |
| light_b | output | 2 | Light code for road B |

## Verification
A wrong stored phase shows up at the light ports in the same cycle it is stored, because the outputs are a direct decode of the phase register. A wrong transition is therefore visible one edge after the sensor values that caused it. A one-hot register that drifts from the binary register appears as a mismatch between the two instances, which run side by side on the same stimulus. Outputs are also sampled after a mid-cycle sensor change, which exposes any path from a sensor straight to a light.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PHASE_W    = $clog2(NUM_PHASES);
  localparam int LIGHT_W    = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_A_GO   = 2'd0,
    PH_A_WARN = 2'd1,
    PH_B_GO   = 2'd2,
    PH_B_WARN = 2'd3
  } phase_t;

  typedef enum logic [LIGHT_W-1:0] {
    LT_GREEN  = 2'b00,
    LT_YELLOW = 2'b01,
    LT_RED    = 2'b10
  } light_t;
endpackage

// File: rtl/tlc_next_phase.sv
module tlc_next_phase
  import tlc_pkg::*;
(
  input  phase_t cur,
  input  logic   sense_a,
  input  logic   sense_b,
  output phase_t nxt
);
  always_comb begin
    unique case (cur)
      PH_A_GO:   nxt = sense_a ? PH_A_GO : PH_A_WARN;
      PH_A_WARN: nxt = PH_B_GO;
      PH_B_GO:   nxt = sense_b ? PH_B_GO : PH_B_WARN;
      default:   nxt = PH_A_GO;
    endcase
  end
endmodule

// File: rtl/tlc_phase_reg.sv
module tlc_phase_reg
  import tlc_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_t nxt,
  output phase_t cur
);
  localparam int SW = ONE_HOT ? NUM_PHASES : PHASE_W;

  logic [SW-1:0] q;
  logic [SW-1:0] d;

  generate
    if (ONE_HOT) begin : g_onehot
      logic legal;
      always_comb begin
        d = '0;
        d[nxt] = 1'b1;
        legal = $onehot(q);
        cur = PH_A_GO;
        for (int i = 0; i < NUM_PHASES; i++)
          if (q[i]) cur = phase_t'(i[PHASE_W-1:0]);
      end
      // an illegal vector is forced back to the A-green position
      always_ff @(posedge clk) begin
        if (rst || !legal) q <= SW'(1);
        else               q <= d;
      end
      // R10: exactly one bit is set once reset has run
      a_r10_onehot_legal: assert property (@(posedge clk) disable iff (rst)
        $onehot(q));
    end else begin : g_binary
      always_comb begin
        d   = SW'(nxt);
        cur = phase_t'(q);
      end
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/tlc_light_map.sv
module tlc_light_map
  import tlc_pkg::*;
(
  input  phase_t cur,
  output light_t lamp_a,
  output light_t lamp_b
);
  always_comb begin
    unique case (cur)
      PH_A_GO:   begin lamp_a = LT_GREEN;  lamp_b = LT_RED;    end
      PH_A_WARN: begin lamp_a = LT_YELLOW; lamp_b = LT_RED;    end
      PH_B_GO:   begin lamp_a = LT_RED;    lamp_b = LT_GREEN;  end
      default:   begin lamp_a = LT_RED;    lamp_b = LT_YELLOW; end
    endcase
  end
endmodule

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sense_a,
  input  logic               sense_b,
  output logic [LIGHT_W-1:0] light_a,
  output logic [LIGHT_W-1:0] light_b
);
  phase_t cur;
  phase_t nxt;
  light_t lamp_a;
  light_t lamp_b;

  tlc_next_phase u_next (
    .cur(cur), .sense_a(sense_a), .sense_b(sense_b), .nxt(nxt)
  );

  tlc_phase_reg #(.ONE_HOT(ONE_HOT)) u_reg (
    .clk(clk), .rst(rst), .nxt(nxt), .cur(cur)
  );

  tlc_light_map u_map (
    .cur(cur), .lamp_a(lamp_a), .lamp_b(lamp_b)
  );

  assign light_a = lamp_a;
  assign light_b = lamp_b;

  // R1: reset lands in A-green
  a_r1_reset_a_green: assert property (@(posedge clk)
    rst |=> (light_a == 2'b00 && light_b == 2'b10));
  // R2: A-green holds while road A is busy
  a_r2_hold_a: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_A_GO && sense_a) |=> cur == PH_A_GO);
  // R4: A-yellow lasts one cycle
  a_r4_a_warn_once: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_A_WARN) |=> cur == PH_B_GO);
  // R5: B-green holds while road B is busy
  a_r5_hold_b: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_B_GO && sense_b) |=> cur == PH_B_GO);
  // R7: B-yellow lasts one cycle
  a_r7_b_warn_once: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_B_WARN) |=> cur == PH_A_GO);
  // R8: code 11 never appears and one road is always red
  a_r8_codes_safe: assert property (@(posedge clk) disable iff (rst)
    light_a != 2'b11 && light_b != 2'b11 &&
    (light_a == 2'b10 || light_b == 2'b10));
endmodule

// File: tb/tlc_ctrl_bench.sv
module tlc_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sa = 1'b0;
  logic sb = 1'b0;
  logic [1:0] la_b, lb_b, la_o, lb_o;

  int checks = 0;
  int errors = 0;
  int mstate = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tlc_ctrl #(.ONE_HOT(1'b0)) u_tlc_ctrl (
    .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb),
    .light_a(la_b), .light_b(lb_b));
  tlc_ctrl #(.ONE_HOT(1'b1)) u_tlc_ctrl_oh (
    .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb),
    .light_a(la_o), .light_b(lb_o));

  function automatic logic [3:0] exp_lights(int s);
    case (s)
      0: return 4'b00_10;
      1: return 4'b01_10;
      2: return 4'b10_00;
      default: return 4'b10_01;
    endcase
  endfunction

  function automatic int model_next(int s, bit r, bit a, bit b);
    if (r) return 0;
    case (s)
      0: return a ? 0 : 1;
      1: return 2;
      2: return b ? 2 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(int s, bit r, bit a, bit b);
    if (r) return "R1";
    case (s)
      0: return a ? "R2" : "R3";
      1: return "R4";
      2: return b ? "R5" : "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, probe mid-cycle, check after the edge
  task automatic step(bit r, bit a, bit b);
    string tg;
    tg = tag_for(mstate, r, a, b);
    @(negedge clk);
    rst = r;
    sa = a;
    sb = b;
    #1;
    chk("R9 mid-cycle sensor change", {la_b, lb_b}, exp_lights(mstate));
    @(posedge clk);
    mstate = model_next(mstate, r, a, b);
    #2;
    chk(tg, {la_b, lb_b}, exp_lights(mstate));
    chk("R10 one-hot matches", {la_o, lb_o}, exp_lights(mstate));
    checks++;
    if (la_b == 2'b11 || lb_b == 2'b11) begin
      errors++;
      $display("FAIL R8: actual %b%b expected no 11 code", la_b, lb_b);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset with both sensors high still yields A-green
    step(1, 1, 1);
    step(1, 1, 1);
    chk("R1 reset lights", {la_b, lb_b}, 4'b00_10);
    // R2: hold A with B busy
    step(0, 1, 1);
    step(0, 1, 0);
    step(0, 1, 1);
    // R3, R4: leave A, yellow ignores sensors
    step(0, 0, 1);
    chk("R8 A-yellow code", {la_b, lb_b}, 4'b01_10);
    step(0, 1, 0);
    // R5: hold B with A busy
    step(0, 1, 1);
    step(0, 0, 1);
    // R6, R7
    step(0, 1, 0);
    chk("R8 B-yellow code", {la_b, lb_b}, 4'b10_01);
    step(0, 1, 1);
    // R1: reset in mid-sequence overrides held sensor
    step(0, 0, 0);
    step(0, 1, 1);
    step(1, 0, 1);
    for (int i = 0; i < 400; i++) begin
      bit r, a, b;
      r = ($urandom % 32) == 0;
      a = $urandom % 2;
      b = $urandom % 2;
      step(r, a, b);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule